// File: doc/BRIEF.md
# Write Permission and Block Protection Controller

This block keeps the status register of a serial memory and decides whether each write request is allowed. It holds a write enable latch, a busy flag for the write cycle, two region-protect bits and a bit that makes the external write-protect pin effective. A command decoder drives it with one-cycle strobes: set enable, clear enable, status write with its data byte, array write with its start address, and write cycle done. The block answers each write request in the same cycle with a grant or a deny. It also gives out the status byte that a status read returns.

A granted write starts a write cycle. The block reports busy until the done strobe arrives, and then clears the enable latch. The protect bits are plain registers with a reset default. The array, the serial shifter and the nonvolatile storage belong to other blocks. The array is split into four equal quarters, selected by the two top address bits. The protect bits pick how many quarters, counted down from the top, refuse writes.

Top module: `wp_guard_unit`

## Requirements
- R1: When idle, status_o is {pin_en, 3'b000, bp[1:0], wel, 1'b0}: pin enable in bit 7, bits 6..4 zero, protect code in bits 3..2, enable latch in bit 1, busy in bit 0.
- R2: After reset the latch, busy flag, protect code and pin enable are all 0, so status_o reads 8'h00.
- R3: A set-enable strobe sets the latch at the next edge. A clear-enable strobe clears it. When both arrive in the same cycle, clear wins.
- R4: With the latch clear, every status or array write request is denied.
- R5: Protect code 2'b00 protects nothing. 2'b01 protects addresses 0x3000..0x3FFF (top bits 11). 2'b10 protects 0x2000..0x3FFF (top bit 1). 2'b11 protects the whole array. An array write that starts in a protected region is denied.
- R6: A granted write sets busy at the next edge. While busy, status_o reads 8'hFF.
- R7: While busy, every write request is denied.
- R8: A done strobe while busy clears both busy and the latch at the next edge.
- R9: A granted status write loads data bit 7 into pin enable and data bits 3..2 into the protect code. Data bits 6..4, 1 and 0 are ignored.
- R10: With pin enable 0, the active-low pin wp_ni has no effect. With pin enable 1 and wp_ni low, status writes are denied. Array writes never depend on the pin.
- R11: A denied request leaves the latch, the protect code and pin enable unchanged, and busy stays 0.
- R12: If a status write and an array write are requested in the same cycle, only the status write can be granted and the array write is denied.
- R13: For each request type, a request raises exactly one of its grant or deny outputs in that cycle. Without a request, both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_set_i | input | 1 | Set-enable strobe |
| wen_clr_i | input | 1 | Clear-enable strobe |
| sr_wr_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Status write data |
| arr_wr_i | input | 1 | Array write request |
| arr_addr_i | input | ADDR_W | Array write start address |
| wr_done_i | input | 1 | Write cycle done strobe |
| wp_ni | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| sr_grant_o | output | 1 | Status write granted |
| sr_deny_o | output | 1 | Status write refused |
| arr_grant_o | output | 1 | Array write granted |
| arr_deny_o | output | 1 | Array write refused |

## Verification
The assertions check the following on every cycle, using only port values:
- Busy forces status to all ones, and the unused bits read zero when idle.
- Grant and deny are mutually exclusive, and no grant happens without the latch.
- A grant leads to busy, and done clears busy and the latch.
- The pin refuses status writes when enabled, and status writes take priority over array writes.

Several things can only be shown by the bench's scenarios, which check a behavioural model on every clock:
- the quarter boundaries of each protect code (0x2FFF against 0x3000, 0x1FFF against 0x2000);
- the masking of ignored status data bits;
- that refused requests leave the stored state unchanged.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int SR_W      = 8;
  localparam int SR_PINEN  = 7;
  localparam int SR_BP_HI  = 3;
  localparam int SR_BP_LO  = 2;
  localparam int SR_WEL    = 1;
  localparam int SR_BUSY   = 0;

  typedef enum logic [1:0] {
    BP_NONE  = 2'b00,
    BP_TOP_Q = 2'b01,
    BP_TOP_H = 2'b10,
    BP_ALL   = 2'b11
  } bp_e;
endpackage

// File: rtl/wpg_wel_busy.sv
module wpg_wel_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic start_i,
  input  logic done_i,
  output logic wel_o,
  output logic busy_o
);
  logic wel_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (busy_q && done_i)   wel_q <= 1'b0;
      else if (clr_i)         wel_q <= 1'b0;
      else if (set_i)         wel_q <= 1'b1;

      if (start_i)            busy_q <= 1'b1;
      else if (done_i)        busy_q <= 1'b0;
    end
  end

  assign wel_o  = wel_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/wpg_prot_bits.sv
module wpg_prot_bits
  import wpg_pkg::*;
#(
  parameter bp_e  RST_BP    = BP_NONE,
  parameter logic RST_PINEN = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       pinen_d_i,
  input  logic [1:0] bp_d_i,
  output logic       pinen_o,
  output bp_e        bp_o
);
  logic pinen_q;
  bp_e  bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pinen_q <= RST_PINEN;
      bp_q    <= RST_BP;
    end else if (load_i) begin
      pinen_q <= pinen_d_i;
      bp_q    <= bp_e'(bp_d_i);
    end
  end

  assign pinen_o = pinen_q;
  assign bp_o    = bp_q;
endmodule

// File: rtl/wpg_region_chk.sv
module wpg_region_chk
  import wpg_pkg::*;
(
  input  bp_e        bp_i,
  input  logic [1:0] quarter_i,
  output logic       prot_o
);
  always_comb begin
    unique case (bp_i)
      BP_NONE:  prot_o = 1'b0;
      BP_TOP_Q: prot_o = (quarter_i == 2'b11);
      BP_TOP_H: prot_o = quarter_i[1];
      default:  prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_guard_unit.sv
module wp_guard_unit
  import wpg_pkg::*;
#(
  parameter int   ADDR_W    = 14,
  parameter bp_e  RST_BP    = BP_NONE,
  parameter logic RST_PINEN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_set_i,
  input  logic              wen_clr_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_data_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wr_done_i,
  input  logic              wp_ni,
  output logic [SR_W-1:0]   status_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o,
  output logic              arr_grant_o,
  output logic              arr_deny_o
);
  localparam int QTR_LSB = ADDR_W - 2;

  logic wel, busy, pinen, prot, pin_lock, sr_ok, arr_ok;
  bp_e  bp;
  logic unused_inputs;

  assign unused_inputs = ^{sr_data_i[6:4], sr_data_i[1:0], arr_addr_i[QTR_LSB-1:0]};

  wpg_wel_busy u_wel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wen_set_i),
    .clr_i   (wen_clr_i),
    .start_i (sr_grant_o | arr_grant_o),
    .done_i  (wr_done_i),
    .wel_o   (wel),
    .busy_o  (busy)
  );

  wpg_prot_bits #(.RST_BP(RST_BP), .RST_PINEN(RST_PINEN)) u_prot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sr_grant_o),
    .pinen_d_i (sr_data_i[SR_PINEN]),
    .bp_d_i    (sr_data_i[SR_BP_HI:SR_BP_LO]),
    .pinen_o   (pinen),
    .bp_o      (bp)
  );

  wpg_region_chk u_region (
    .bp_i      (bp),
    .quarter_i (arr_addr_i[ADDR_W-1:QTR_LSB]),
    .prot_o    (prot)
  );

  assign pin_lock = pinen & ~wp_ni;
  assign sr_ok    = wel & ~busy & ~pin_lock;
  assign arr_ok   = wel & ~busy & ~prot & ~sr_wr_i;  // status write has priority

  assign sr_grant_o  = sr_wr_i  &  sr_ok;
  assign sr_deny_o   = sr_wr_i  & ~sr_ok;
  assign arr_grant_o = arr_wr_i &  arr_ok;
  assign arr_deny_o  = arr_wr_i & ~arr_ok;

  always_comb begin
    if (busy) begin
      status_o = '1;
    end else begin
      status_o                    = '0;
      status_o[SR_PINEN]          = pinen;
      status_o[SR_BP_HI:SR_BP_LO] = bp;
      status_o[SR_WEL]            = wel;
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wen_set_i,
  input logic       wen_clr_i,
  input logic       sr_wr_i,
  input logic       arr_wr_i,
  input logic       wr_done_i,
  input logic       wp_ni,
  input logic [7:0] status_o,
  input logic       sr_grant_o,
  input logic       sr_deny_o,
  input logic       arr_grant_o,
  input logic       arr_deny_o
);
  a_r6_busy_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> status_o == 8'hFF);

  a_r1_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> status_o[6:4] == 3'b000);

  a_r13_sr_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |-> $countones({sr_grant_o, sr_deny_o}) == 1);

  a_r13_arr_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_i |-> $countones({arr_grant_o, arr_deny_o}) == 1);

  a_r13_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_wr_i && !arr_wr_i) |-> !(sr_grant_o || sr_deny_o || arr_grant_o || arr_deny_o));

  a_r4_grant_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_grant_o || arr_grant_o) |-> (status_o[1] && !status_o[0]));

  a_r7_busy_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> !(sr_grant_o || arr_grant_o));

  a_r6_grant_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_grant_o || arr_grant_o) |=> status_o[0]);

  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && wr_done_i) |=> (!status_o[0] && !status_o[1]));

  a_r10_pin_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && !status_o[0] && status_o[7] && !wp_ni) |-> sr_deny_o);

  a_r12_status_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |-> !arr_grant_o);

  a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_i |=> !status_o[1] || status_o[0]);

  a_r11_deny_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sr_deny_o || arr_deny_o) && !sr_grant_o && !arr_grant_o && !status_o[0]
      && !wen_set_i && !wen_clr_i) |=> $stable(status_o));
endmodule

bind wp_guard_unit wp_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wen_set_i   (wen_set_i),
  .wen_clr_i   (wen_clr_i),
  .sr_wr_i     (sr_wr_i),
  .arr_wr_i    (arr_wr_i),
  .wr_done_i   (wr_done_i),
  .wp_ni       (wp_ni),
  .status_o    (status_o),
  .sr_grant_o  (sr_grant_o),
  .sr_deny_o   (sr_deny_o),
  .arr_grant_o (arr_grant_o),
  .arr_deny_o  (arr_deny_o)
);

// File: tb/tb_wp_guard_unit.sv
module tb_wp_guard_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen_set = 0, wen_clr = 0, sr_wr = 0, arr_wr = 0, wr_done = 0, wp_n = 1;
  logic [7:0]  sr_data = '0;
  logic [13:0] arr_addr = '0;
  logic [7:0]  status;
  logic        sr_grant, sr_deny, arr_grant, arr_deny;

  int checks = 0, errors = 0, cycles = 0;
  int m_wel = 0, m_busy = 0, m_bp = 0, m_pinen = 0;

  always #4 clk = ~clk;

  wp_guard_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .wen_set_i(wen_set), .wen_clr_i(wen_clr),
    .sr_wr_i(sr_wr), .sr_data_i(sr_data), .arr_wr_i(arr_wr), .arr_addr_i(arr_addr),
    .wr_done_i(wr_done), .wp_ni(wp_n), .status_o(status),
    .sr_grant_o(sr_grant), .sr_deny_o(sr_deny), .arr_grant_o(arr_grant), .arr_deny_o(arr_deny)
  );

  function automatic bit prot_at(int bp, int a);
    case (bp)
      0: return 1'b0;
      1: return a >= 'h3000;
      2: return a >= 'h2000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare at mid-cycle, then advance the model at the edge
  task automatic cyc(string tag, bit set, bit clr, bit srw, logic [7:0] d,
                     bit aw, logic [13:0] a, bit done, bit pin_n);
    bit e_sg, e_ag;
    int e_st;
    wen_set = set; wen_clr = clr; sr_wr = srw; sr_data = d;
    arr_wr = aw; arr_addr = a; wr_done = done; wp_n = pin_n;
    #1;
    e_st = m_busy ? 'hFF : (m_pinen << 7) | (m_bp << 2) | (m_wel << 1);
    e_sg = srw && !m_busy && m_wel && !(m_pinen && !pin_n);
    e_ag = aw && !srw && !m_busy && m_wel && !prot_at(m_bp, int'(a));
    chk(tag, "status", int'(status), e_st);
    chk(tag, "sr_grant", int'(sr_grant), int'(e_sg));
    chk(tag, "sr_deny", int'(sr_deny), int'(srw && !e_sg));
    chk(tag, "arr_grant", int'(arr_grant), int'(e_ag));
    chk(tag, "arr_deny", int'(arr_deny), int'(aw && !e_ag));
    @(posedge clk);
    if (m_busy && done) m_wel = 0;
    else if (clr) m_wel = 0;
    else if (set) m_wel = 1;
    if (e_sg) begin m_pinen = int'(d[7]); m_bp = int'(d[3:2]); end
    if (e_sg || e_ag) m_busy = 1;
    else if (done) m_busy = 0;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 8'h00, 0, 14'h0, 0, 1);
  endtask

  task automatic set_wel(string tag);
    cyc(tag, 1, 0, 0, 8'h00, 0, 14'h0, 0, 1);
  endtask

  task automatic finish_write(string tag);
    idle(tag);
    cyc(tag, 0, 0, 0, 8'h00, 0, 14'h0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R2");
    chk("R2", "status_after_reset", int'(status), 0);
    // R4: no latch, both kinds of write refused
    cyc("R4", 0, 0, 1, 8'h8C, 0, 14'h0, 0, 1);
    cyc("R4", 0, 0, 0, 8'h00, 1, 14'h0100, 0, 1);
    // R3: set, clear, then both together (clear wins)
    set_wel("R3");
    cyc("R3", 0, 1, 0, 8'h00, 0, 14'h0, 0, 1);
    cyc("R3", 1, 1, 0, 8'h00, 0, 14'h0, 0, 1);
    idle("R3");
    // R9/R10: pin low but pin enable 0 -> grant; ignored bits set in data
    set_wel("R9");
    cyc("R10", 0, 0, 1, 8'hFF, 0, 14'h0, 0, 0);
    // R6/R7: busy reads FF, requests refused
    cyc("R7", 0, 0, 1, 8'h00, 1, 14'h0, 0, 1);
    cyc("R6", 0, 0, 0, 8'h00, 1, 14'h0010, 0, 1);
    cyc("R8", 0, 0, 0, 8'h00, 0, 14'h0, 1, 1);
    idle("R1");
    chk("R1", "status_layout", int'(status), 'h8C);
    // R10/R11: pin low with pin enable 1 refuses status write; latch kept
    set_wel("R11");
    cyc("R10", 0, 0, 1, 8'h00, 0, 14'h0, 0, 0);
    idle("R11");
    chk("R11", "wel_kept", int'(status), 'h8E);
    // R5: protect all
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h0000, 0, 1);
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h1FFF, 0, 1);
    // reprogram to top quarter with pin high
    cyc("R9", 0, 0, 1, 8'h84, 0, 14'h0, 0, 1);
    finish_write("R8");
    set_wel("R5");
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h3000, 0, 1);
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h2FFF, 0, 0);
    finish_write("R8");
    // top half
    set_wel("R5");
    cyc("R9", 0, 0, 1, 8'h08, 0, 14'h0, 0, 1);
    finish_write("R8");
    set_wel("R5");
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h2000, 0, 1);
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h1FFF, 0, 1);
    finish_write("R8");
    // nothing protected, pin enable off: top address writable
    set_wel("R5");
    cyc("R9", 0, 0, 1, 8'h73, 0, 14'h0, 0, 1);
    finish_write("R8");
    chk("R9", "ignored_bits", int'(status), 'h00);
    set_wel("R5");
    cyc("R5", 0, 0, 0, 8'h00, 1, 14'h3FFF, 0, 1);
    finish_write("R8");
    // R12: simultaneous requests
    set_wel("R12");
    cyc("R12", 0, 0, 1, 8'h04, 1, 14'h0000, 0, 1);
    finish_write("R12");
    idle("R13");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule